// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a PS/2 serial receiver. It turns the raw byte stream from a keyboard into one event per key action. A keyboard reports a key action as a scan code byte, and that byte may come after one or two prefix bytes. One prefix marks an extended key and the other marks a key release. The decoder holds those prefixes as pending flags. When the code byte arrives, it emits a single event that carries the code, an extended bit and a release bit. When a key is held down, the keyboard sends its code again and again. Each repeat leaves the block as a separate press event.

Some bytes are not key data: the acknowledge byte (FA) and the echo byte (EE). These go out on a response strobe of their own and never appear as key events. The block also tracks whether the left and right shift keys are held. Working out the shifted character, and so the ASCII value, is left to the host.

A frame error reported by the receiver drops any half-finished prefix sequence. This keeps a lost byte from corrupting the next event.

Top module: `kbd_event_decoder`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, evt_valid, resp_valid, evt_code, evt_ext, evt_rel, resp_code, shift_l and shift_r are all 0.
- R2: An accepted byte (byte_valid high, frame_err low) that is not E0, F0, FA or EE produces evt_valid high for exactly the following cycle. In that cycle evt_code equals the byte. With no prefix pending, evt_ext=0 and evt_rel=0, which marks a press, and every repeat of the code gives another press event.
- R3: An accepted F0 sets a pending release flag, and the next key byte is reported with evt_rel=1.
- R4: An accepted E0 sets a pending extended flag, and the next key byte is reported with evt_ext=1. E0 then F0 before the code gives evt_ext=1 and evt_rel=1, and so does F0 then E0.
- R5: A prefix byte (E0 or F0) never raises evt_valid or resp_valid in the following cycle.
- R6: Both pending flags clear once an event is emitted, so the next key byte with no new prefix is a plain press.
- R7: frame_err high in a cycle clears both pending flags. It also discards any byte presented in that cycle: no event, no response and no shift change follow.
- R8: An accepted FA or EE raises resp_valid for the following cycle, with resp_code equal to the byte and evt_valid low. The pending flags are left as they were.
- R9: shift_l becomes 1 after a press event of non-extended code 12 and 0 after its release event. shift_r does the same for non-extended code 59. Extended events with those codes leave both bits unchanged.
- R10: With byte_valid low and frame_err low, no event or response follows, and the pending flags and shift bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| frame_err | input | 1 | Receiver reports a bad frame |
| evt_valid | output | 1 | One-cycle key event strobe |
| evt_code | output | 8 | Scan code of the event |
| evt_ext | output | 1 | Event belongs to an extended key |
| evt_rel | output | 1 | Event is a release (0 = press) |
| resp_valid | output | 1 | One-cycle keyboard response strobe |
| resp_code | output | 8 | Response byte (FA or EE) |
| shift_l | output | 1 | Left shift currently held |
| shift_r | output | 1 | Right shift currently held |

## Verification
The hardest states to reach from the ports are the interleavings. One is a response byte arriving between a prefix and its code. Another is a frame error striking after a prefix and before the code. A third is an extended shift code arriving while a plain shift is held. Directed sequences build each of these on purpose. After that, a seeded random stream draws its bytes mostly from the prefix, response and shift values, so long runs of mixed prefixes happen often. A bench model tracks the pending flags and checks every output on every cycle.

// File: rtl/kbd_evt_pkg.sv
// Package: byte values and byte classes shared by the event decoder.
// Assumes 8-bit bytes from a PS/2 receiver.
package kbd_evt_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] PFX_EXT  = 8'hE0;
    localparam logic [BYTE_W-1:0] PFX_REL  = 8'hF0;
    localparam logic [BYTE_W-1:0] RSP_ACK  = 8'hFA;
    localparam logic [BYTE_W-1:0] RSP_ECHO = 8'hEE;

    typedef enum logic [1:0] {
        BC_KEY  = 2'd0,
        BC_EXT  = 2'd1,
        BC_REL  = 2'd2,
        BC_RESP = 2'd3
    } byte_class_t;

    // Map a received byte to its class.
    function automatic byte_class_t classify(input logic [BYTE_W-1:0] b);
        if (b == PFX_EXT)                      return BC_EXT;
        else if (b == PFX_REL)                 return BC_REL;
        else if (b == RSP_ACK || b == RSP_ECHO) return BC_RESP;
        else                                   return BC_KEY;
    endfunction
endpackage

// File: rtl/kbd_byte_classifier.sv
// Module: kbd_byte_classifier
// Purely combinational front end. It qualifies each byte strobe with the
// frame error and raises one strobe per byte class.
// Assumes frame_err and byte_valid are already synchronous to clk.
module kbd_byte_classifier
    import kbd_evt_pkg::*;
(
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              frame_err,
    output logic              take_key,
    output logic              take_ext,
    output logic              take_rel,
    output logic              take_resp
);
    byte_class_t cls;
    logic        accept;

    // Decode the class and gate it with an error-free valid byte.
    always_comb begin
        cls       = classify(byte_data);
        accept    = byte_valid && !frame_err;
        take_key  = accept && (cls == BC_KEY);
        take_ext  = accept && (cls == BC_EXT);
        take_rel  = accept && (cls == BC_REL);
        take_resp = accept && (cls == BC_RESP);
    end
endmodule

// File: rtl/kbd_prefix_tracker.sv
// Module: kbd_prefix_tracker
// Holds the pending extended and release flags between prefix bytes and
// the code byte. Prefixes may come in any order. A frame error or an
// emitted key event clears both flags; response bytes leave them alone.
module kbd_prefix_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_err,
    input  logic take_key,
    input  logic take_ext,
    input  logic take_rel,
    output logic pend_ext,
    output logic pend_rel
);
    // Update the pending flags from prefix, key and error strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_err || take_key) begin
            pend_ext <= 1'b0;
            pend_rel <= 1'b0;
        end else begin
            if (take_ext) pend_ext <= 1'b1;
            if (take_rel) pend_rel <= 1'b1;
        end
    end
endmodule

// File: rtl/kbd_event_stage.sv
// Module: kbd_event_stage
// Output register for key events and keyboard responses. The strobes
// last one cycle. Code and flag fields keep their last value between
// strobes.
module kbd_event_stage
    import kbd_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_key,
    input  logic              take_resp,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              pend_ext,
    input  logic              pend_rel,
    output logic              evt_valid,
    output logic [BYTE_W-1:0] evt_code,
    output logic              evt_ext,
    output logic              evt_rel,
    output logic              resp_valid,
    output logic [BYTE_W-1:0] resp_code
);
    // Register a key event merged with its pending prefix flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= '0;
            evt_ext   <= 1'b0;
            evt_rel   <= 1'b0;
        end else begin
            evt_valid <= take_key;
            if (take_key) begin
                evt_code <= byte_data;
                evt_ext  <= pend_ext;
                evt_rel  <= pend_rel;
            end
        end
    end

    // Register keyboard response bytes on their own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= '0;
        end else begin
            resp_valid <= take_resp;
            if (take_resp) resp_code <= byte_data;
        end
    end
endmodule

// File: rtl/kbd_shift_tracker.sv
// Module: kbd_shift_tracker
// One held bit per modifier code in MOD_CODES. Lane i watches byte
// MOD_CODES[i*8 +: 8]. A non-extended press sets the bit and a
// non-extended release clears it. Extended events never touch it.
module kbd_shift_tracker
    import kbd_evt_pkg::*;
#(
    parameter int                      NUM_MOD   = 2,
    parameter logic [NUM_MOD*BYTE_W-1:0] MOD_CODES = 16'h5912
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_key,
    input  logic [BYTE_W-1:0]  byte_data,
    input  logic               pend_ext,
    input  logic               pend_rel,
    output logic [NUM_MOD-1:0] held
);
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
        localparam logic [BYTE_W-1:0] CODE = MOD_CODES[i*BYTE_W +: BYTE_W];
        logic hit;

        // Detect a plain (non-extended) event for this lane's code.
        always_comb hit = take_key && !pend_ext && (byte_data == CODE);

        // Track the held state of this modifier.
        always_ff @(posedge clk) begin
            if (!rst_n)   held[i] <= 1'b0;
            else if (hit) held[i] <= !pend_rel;
        end
    end
endmodule

// File: rtl/kbd_event_decoder.sv
// Module: kbd_event_decoder (top)
// Merges E0/F0 prefix bytes into flags on the next code byte and emits one
// event per complete sequence. Response bytes go out on their own strobe.
// Left and right shift held state is tracked.
// Assumes at most one byte per cycle from a synchronous receiver.
module kbd_event_decoder
    import kbd_evt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LSHIFT_CODE = 8'h12,
    parameter logic [BYTE_W-1:0] RSHIFT_CODE = 8'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              frame_err,
    output logic              evt_valid,
    output logic [BYTE_W-1:0] evt_code,
    output logic              evt_ext,
    output logic              evt_rel,
    output logic              resp_valid,
    output logic [BYTE_W-1:0] resp_code,
    output logic              shift_l,
    output logic              shift_r
);
    localparam int NUM_MOD = 2;
    localparam logic [NUM_MOD*BYTE_W-1:0] MOD_CODES = {RSHIFT_CODE, LSHIFT_CODE};

    logic               take_key, take_ext, take_rel, take_resp;
    logic               pend_ext, pend_rel;
    logic [NUM_MOD-1:0] held;

    kbd_byte_classifier u_cls (
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err),
        .take_key   (take_key),
        .take_ext   (take_ext),
        .take_rel   (take_rel),
        .take_resp  (take_resp)
    );

    kbd_prefix_tracker u_pfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_err (frame_err),
        .take_key  (take_key),
        .take_ext  (take_ext),
        .take_rel  (take_rel),
        .pend_ext  (pend_ext),
        .pend_rel  (pend_rel)
    );

    kbd_event_stage u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_key   (take_key),
        .take_resp  (take_resp),
        .byte_data  (byte_data),
        .pend_ext   (pend_ext),
        .pend_rel   (pend_rel),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code),
        .evt_ext    (evt_ext),
        .evt_rel    (evt_rel),
        .resp_valid (resp_valid),
        .resp_code  (resp_code)
    );

    kbd_shift_tracker #(
        .NUM_MOD   (NUM_MOD),
        .MOD_CODES (MOD_CODES)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_key  (take_key),
        .byte_data (byte_data),
        .pend_ext  (pend_ext),
        .pend_rel  (pend_rel),
        .held      (held)
    );

    // Expose the tracked modifier bits.
    always_comb begin
        shift_l = held[0];
        shift_r = held[1];
    end
endmodule

// File: rtl/kbd_event_decoder_chk.sv
// Module: kbd_event_decoder_chk
// Port-level temporal checks for kbd_event_decoder, attached by bind.
module kbd_event_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       frame_err,
    input logic       evt_valid,
    input logic [7:0] evt_code,
    input logic       resp_valid,
    input logic [7:0] resp_code,
    input logic       shift_l,
    input logic       shift_r
);
    // R2
    evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ($past(byte_valid) && !$past(frame_err) && evt_code == $past(byte_data)));

    // R5
    pfx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (byte_data == 8'hE0 || byte_data == 8'hF0)) |=> (!evt_valid && !resp_valid));

    // R7
    ferr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> (!evt_valid && !resp_valid && $stable(shift_l) && $stable(shift_r)));

    // R8
    resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(byte_valid) && (resp_code == 8'hFA || resp_code == 8'hEE)
                        && resp_code == $past(byte_data)));

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_valid, resp_valid}));

    // R9
    shl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_l != $past(shift_l)) |-> (evt_valid && evt_code == 8'h12));

    // R9
    shr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_r != $past(shift_r)) |-> (evt_valid && evt_code == 8'h59));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !frame_err) |=> (!evt_valid && !resp_valid));
endmodule

bind kbd_event_decoder kbd_event_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_err  (frame_err),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .shift_l    (shift_l),
    .shift_r    (shift_r)
);

// File: tb/kbd_event_decoder_bench.sv
// Bench: directed sequences followed by a seeded random byte stream.
// A reference model predicts the outputs after each clock edge. Inputs
// are driven and outputs compared on the falling edge.
module kbd_event_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       frame_err = 1'b0;
    logic       evt_valid, evt_ext, evt_rel, resp_valid, shift_l, shift_r;
    logic [7:0] evt_code, resp_code;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference model state
    bit       m_pext, m_prel, m_shl, m_shr;
    bit       x_ev, x_ext, x_rel, x_rv;
    bit [7:0] x_code, x_rcode;

    always #10 clk = ~clk;

    kbd_event_decoder u_kbd_event_decoder (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_err(frame_err), .evt_valid(evt_valid), .evt_code(evt_code),
        .evt_ext(evt_ext), .evt_rel(evt_rel), .resp_valid(resp_valid),
        .resp_code(resp_code), .shift_l(shift_l), .shift_r(shift_r)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model one clock edge given the inputs presented before it.
    task automatic model_step(input bit v, input bit [7:0] d, input bit fe);
        x_ev = 0; x_rv = 0;
        if (fe) begin
            m_pext = 0; m_prel = 0;
        end else if (v) begin
            if (d == 8'hE0) m_pext = 1;
            else if (d == 8'hF0) m_prel = 1;
            else if (d == 8'hFA || d == 8'hEE) begin
                x_rv = 1; x_rcode = d;
            end else begin
                x_ev = 1; x_code = d; x_ext = m_pext; x_rel = m_prel;
                if (!m_pext && d == 8'h12) m_shl = !m_prel;
                if (!m_pext && d == 8'h59) m_shr = !m_prel;
                m_pext = 0; m_prel = 0;
            end
        end
    endtask

    // Compare every output against the model, tagged by requirement.
    task automatic compare_all(input string req);
        chk(req, "evt_valid", evt_valid, x_ev);
        if (x_ev) begin
            chk(req, "evt_code", evt_code, x_code);
            chk(req, "evt_ext", evt_ext, x_ext);
            chk(req, "evt_rel", evt_rel, x_rel);
        end
        chk(req, "resp_valid", resp_valid, x_rv);
        if (x_rv) chk(req, "resp_code", resp_code, x_rcode);
        chk("R9", "shift_l", shift_l, m_shl);
        chk("R9", "shift_r", shift_r, m_shr);
    endtask

    // Drive one cycle at the falling edge, then check after the next rising edge.
    task automatic cyc(input bit v, input bit [7:0] d, input bit fe, input string req);
        byte_valid = v; byte_data = d; frame_err = fe;
        model_step(v, d, fe);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic send(input bit [7:0] d, input string req);
        cyc(1'b1, d, 1'b0, req);
    endtask

    function automatic bit [7:0] pick_byte();
        int r = $urandom_range(0, 9);
        case (r)
            0: return 8'hE0;
            1: return 8'hF0;
            2: return 8'hFA;
            3: return 8'hEE;
            4: return 8'h12;
            5: return 8'h59;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4242));
        m_pext = 0; m_prel = 0; m_shl = 0; m_shr = 0;
        x_ev = 0; x_rv = 0; x_code = 0; x_rcode = 0; x_ext = 0; x_rel = 0;
        @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'h1C;  // ignored during reset
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "evt_valid", evt_valid, 0);
        chk("R1", "resp_valid", resp_valid, 0);
        chk("R1", "evt_code", evt_code, 0);
        chk("R1", "resp_code", resp_code, 0);
        chk("R1", "shift", {shift_l, shift_r}, 0);
        byte_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "evt_valid", evt_valid, 0);
        chk("R1", "evt_ext_rel", {evt_ext, evt_rel}, 0);

        // R2: press and typematic repeats
        send(8'h1C, "R2"); send(8'h1C, "R2"); send(8'h1C, "R2");
        // R3: release
        send(8'hF0, "R5"); send(8'h1C, "R3");
        // R6: next plain press
        send(8'h32, "R6");
        // R4: extended press, E0 F0 release, F0 E0 release
        send(8'hE0, "R5"); send(8'h75, "R4");
        send(8'hE0, "R5"); send(8'hF0, "R5"); send(8'h75, "R4");
        send(8'hF0, "R5"); send(8'hE0, "R5"); send(8'h75, "R4");
        // R8: response between prefix and code keeps pending flags
        send(8'hF0, "R5"); send(8'hFA, "R8"); send(8'h2B, "R8");
        send(8'hEE, "R8");
        // R7: frame error clears pending and drops its own byte
        send(8'hE0, "R5"); send(8'hF0, "R5");
        cyc(1'b1, 8'h12, 1'b1, "R7");
        send(8'h12, "R7");  // plain press, sets shift_l
        // R9: extended 12 ignored, release clears
        send(8'hE0, "R5"); send(8'hF0, "R5"); send(8'h12, "R9");
        send(8'h59, "R9");
        send(8'hF0, "R5"); send(8'h12, "R9");
        send(8'hF0, "R5"); send(8'h59, "R9");
        // R10: idle cycles after a pending prefix
        send(8'hE0, "R5");
        cyc(1'b0, 8'h59, 1'b0, "R10");
        cyc(1'b0, 8'hAA, 1'b0, "R10");
        send(8'h59, "R10");  // extended: shift_r unchanged, ext=1

        // Random stream
        for (int i = 0; i < 4000; i++) begin
            bit v  = ($urandom_range(0, 9) < 6);
            bit fe = ($urandom_range(0, 31) == 0);
            cyc(v, pick_byte(), fe, "R2");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule